// File: doc/BRIEF.md
# ASID-Tagged I/O Translation Cache with Selective Invalidation

This block is a small fully-associative translation cache that sits in front of an I/O memory management unit's table walker. Every entry holds one 4 KiB page translation: a 7-bit address-space identifier, the virtual page number (virtual address bits 31:12), a physical frame number and three permission flags (read, write, non-secure). A client presents an identifier and a virtual page. One cycle later the block reports a hit, with the frame and flags, or a miss.

Entries arrive from an external walker through a single-cycle refill port. A refill that names an identifier and page already held replaces that entry in place. Otherwise the refill takes the slot under a round-robin pointer. That pointer only covers the number of active lines set by software.

Invalidation is driven by one encoded 32-bit command word. The word can drop everything, or every page of one identifier. It can also drop a 4 MiB section or a 16 KiB group, either across all identifiers or limited to one. The command is held for one cycle and then applied. In that cycle, lookups already treat the targeted entries as gone.

Top module: `iotlb_top`

## Requirements
- R1: A lookup accepted in cycle t (lk_valid and lk_ready both high) produces exactly one of lk_hit or lk_miss in cycle t+1. The result is a hit only when a valid entry matches both lk_asid and lk_vpn (virtual address bits 31:12). On a hit, lk_pfn and {lk_rd, lk_wr, lk_ns} carry that entry's frame and flags. When no lookup was accepted, neither flag is raised.
- R2: A refill presented in cycle t (rf_valid high) is visible to a lookup presented in cycle t+1.
- R3: A refill whose identifier and page equal those of a valid entry overwrites that entry. No second copy is created and the replacement pointer does not move.
- R4: Other refills go to the slot under a round-robin pointer, which steps through slots 0 to L-1 and then wraps. L is the 6-bit cfg_active_lines value; 0, or any value above ENTRIES, means ENTRIES. A slot at index L or higher is never allocated, so with L=2 a third new page evicts the first.
- R5: In a flush command, bits 1:0 choose address matching. The value 0 matches every address. With bit 31 low, command 0 invalidates every entry.
- R6: Bit 31 of a flush command restricts it to entries whose identifier equals command bits 30:24. Entries of other identifiers survive.
- R7: Match mode 2 (section) invalidates entries whose virtual address bits 31:22 equal command bits 19:10.
- R8: Match mode 3 (group) invalidates entries whose virtual address bits 31:14 equal command bits 19:2.
- R9: Match mode 1 invalidates nothing.
- R10: A flush written in cycle t is applied at the end of cycle t+1, and a lookup in cycle t+1 does not hit on an entry the flush selects. A lookup in cycle t itself still sees the old contents.
- R11: With hit-under-miss off (cfg_hit_under_miss written 0), an accepted miss drops lk_ready from the next cycle until the cycle after a refill. Lookups presented while lk_ready is low raise neither lk_hit nor lk_miss. With hit-under-miss on, lk_ready stays high.
- R12: After reset all entries are invalid, lk_hit and lk_miss are low, and lk_ready is high. Hit-under-miss is on and all ENTRIES lines are active.
- R13: When a pending flush and a refill land on the same clock edge, the refilled entry survives even if the flush would have selected it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_hit_under_miss | input | 1 | 1 lets lookups continue while a miss is outstanding |
| cfg_active_lines | input | 6 | Number of slots the replacement pointer may use (0 = all) |
| fl_we | input | 1 | Write strobe for the flush command |
| fl_cmd | input | 32 | Flush command word |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_vpn | input | 20 | Lookup virtual page (address bits 31:12) |
| lk_ready | output | 1 | Lookups are accepted this cycle |
| lk_hit | output | 1 | Previous accepted lookup hit |
| lk_miss | output | 1 | Previous accepted lookup missed |
| lk_pfn | output | PFN_W | Frame of the hit entry, zero otherwise |
| lk_rd | output | 1 | Read permission of the hit entry |
| lk_wr | output | 1 | Write permission of the hit entry |
| lk_ns | output | 1 | Non-secure flag of the hit entry |
| rf_valid | input | 1 | Refill strobe |
| rf_asid | input | 7 | Refill identifier |
| rf_vpn | input | 20 | Refill virtual page |
| rf_pfn | input | PFN_W | Refill frame |
| rf_rd | input | 1 | Refill read permission |
| rf_wr | input | 1 | Refill write permission |
| rf_ns | input | 1 | Refill non-secure flag |

## Verification
Lookup results are due one edge after the request. Refills and configuration writes take effect at the edge where they are presented. A flush acts on lookups in the following cycle and on storage at the edge that ends that cycle. The bench drives inputs on the falling edge and advances a reference model at the rising edge, using the inputs that were stable before it. It compares every output at the next falling edge, so each expected value already counts the single register stage. Directed sequences pin the same-cycle flush and lookup case, flush and refill on one edge, pointer wrap under a reduced line count, and the stall without hit-under-miss. A seeded random phase then mixes all four ports.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    localparam int ASID_W   = 7;
    localparam int VPN_W    = 20;
    localparam int LINES_W  = 6;
    localparam int SECT_LSB = 10;   // VA[31:22] -> page bits [19:10]
    localparam int GRP_LSB  = 2;    // VA[31:14] -> page bits [19:2]

    typedef enum logic [1:0] {
        FM_ANY     = 2'd0,
        FM_NOP     = 2'd1,
        FM_SECTION = 2'd2,
        FM_GROUP   = 2'd3
    } flush_mode_e;

    typedef struct packed {
        logic              by_asid;
        logic [ASID_W-1:0] asid;
        flush_mode_e       mode;
        logic [VPN_W-1:0]  page;
    } flush_cmd_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ns;
    } perm_t;

    function automatic flush_cmd_t unpack_flush(input logic [31:0] w);
        flush_cmd_t c;
        c.by_asid = w[31];
        c.asid    = w[30:24];
        c.mode    = flush_mode_e'(w[1:0]);
        c.page    = w[19:0];
        return c;
    endfunction

    function automatic logic flush_selects(input flush_cmd_t c,
                                           input logic [ASID_W-1:0] asid,
                                           input logic [VPN_W-1:0] page);
        logic addr_ok;
        case (c.mode)
            FM_ANY:     addr_ok = 1'b1;
            FM_SECTION: addr_ok = (page[VPN_W-1:SECT_LSB] == c.page[VPN_W-1:SECT_LSB]);
            FM_GROUP:   addr_ok = (page[VPN_W-1:GRP_LSB] == c.page[VPN_W-1:GRP_LSB]);
            default:    addr_ok = 1'b0;
        endcase
        return addr_ok && (!c.by_asid || (asid == c.asid));
    endfunction

endpackage

// File: rtl/iotlb_cam.sv
module iotlb_cam
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic               kill_en,
    input  flush_cmd_t         kill_cmd,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  perm_t              wr_perm,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] dup_vec,
    output logic [PFN_W-1:0]   hit_pfn,
    output perm_t              hit_perm
);

    logic [ENTRIES-1:0][PFN_W-1:0] pfn_sel;
    logic [ENTRIES-1:0][2:0]       perm_sel;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic              vld_q;
        logic [ASID_W-1:0] asid_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [PFN_W-1:0]  pfn_q;
        perm_t             perm_q;
        logic              sel_wr;
        logic              killed;

        assign sel_wr = wr_en && (wr_idx == IDX_W'(i));
        assign killed = kill_en && flush_selects(kill_cmd, asid_q, vpn_q);

        // refill is ordered after the flush on a shared edge
        always_ff @(posedge clk) begin
            if (rst)         vld_q <= 1'b0;
            else if (sel_wr) vld_q <= 1'b1;
            else if (killed) vld_q <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (sel_wr) begin
                asid_q <= wr_asid;
                vpn_q  <= wr_vpn;
                pfn_q  <= wr_pfn;
                perm_q <= wr_perm;
            end
        end

        assign hit_vec[i]  = vld_q && !killed && (asid_q == lk_asid) && (vpn_q == lk_vpn);
        assign dup_vec[i]  = vld_q && (asid_q == wr_asid) && (vpn_q == wr_vpn);
        assign pfn_sel[i]  = hit_vec[i] ? pfn_q : '0;
        assign perm_sel[i] = hit_vec[i] ? perm_q : 3'b000;
    end

    always_comb begin
        hit_pfn  = '0;
        hit_perm = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            hit_pfn  = hit_pfn | pfn_sel[k];
            hit_perm = hit_perm | perm_t'(perm_sel[k]);
        end
    end

endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] lines,
    input  logic             advance,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] ptr_q;
    logic [CNT_W-1:0] nxt;

    // a pointer left beyond a shrunk window restarts at slot 0
    assign slot = (CNT_W'(ptr_q) >= lines) ? '0 : ptr_q;
    assign nxt  = CNT_W'(slot) + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)          ptr_q <= '0;
        else if (advance) ptr_q <= (nxt >= lines) ? '0 : IDX_W'(nxt);
    end

endmodule

// File: rtl/iotlb_top.sv
module iotlb_top
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_hit_under_miss,
    input  logic [LINES_W-1:0] cfg_active_lines,
    input  logic               fl_we,
    input  logic [31:0]        fl_cmd,
    input  logic               lk_valid,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_ready,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic               lk_rd,
    output logic               lk_wr,
    output logic               lk_ns,
    input  logic               rf_valid,
    input  logic [ASID_W-1:0]  rf_asid,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic [PFN_W-1:0]   rf_pfn,
    input  logic               rf_rd,
    input  logic               rf_wr,
    input  logic               rf_ns
);

    logic               hum_q;
    logic [LINES_W-1:0] lines_q;
    logic [CNT_W-1:0]   lines_eff;
    logic               fl_pend_q;
    flush_cmd_t         fl_cmd_q;
    logic               miss_pend_q;

    logic [ENTRIES-1:0] hit_vec, dup_vec;
    logic [PFN_W-1:0]   hit_pfn;
    perm_t              hit_perm, wr_perm;
    logic               any_hit, dup_any, accept, advance;
    logic [IDX_W-1:0]   dup_idx, slot, wr_idx;

    logic               hit_q, miss_q;
    logic [PFN_W-1:0]   pfn_q;
    perm_t              perm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hum_q   <= 1'b1;
            lines_q <= '0;
        end else if (cfg_we) begin
            hum_q   <= cfg_hit_under_miss;
            lines_q <= cfg_active_lines;
        end
    end

    assign lines_eff = (lines_q == '0 || int'(lines_q) > ENTRIES) ? CNT_W'(ENTRIES)
                                                                  : CNT_W'(lines_q);

    always_ff @(posedge clk) begin
        if (rst) fl_pend_q <= 1'b0;
        else     fl_pend_q <= fl_we;
    end

    always_ff @(posedge clk) begin
        if (fl_we) fl_cmd_q <= unpack_flush(fl_cmd);
    end

    assign lk_ready = hum_q || !miss_pend_q;
    assign accept   = lk_valid && lk_ready;
    assign any_hit  = |hit_vec;
    assign dup_any  = |dup_vec;

    always_comb begin
        dup_idx = '0;
        for (int k = 0; k < ENTRIES; k++)
            if (dup_vec[k]) dup_idx = IDX_W'(k);
    end

    assign wr_idx  = dup_any ? dup_idx : slot;
    assign advance = rf_valid && !dup_any;
    assign wr_perm = '{rd: rf_rd, wr: rf_wr, ns: rf_ns};

    iotlb_cam #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .lk_asid  (lk_asid),
        .lk_vpn   (lk_vpn),
        .kill_en  (fl_pend_q),
        .kill_cmd (fl_cmd_q),
        .wr_en    (rf_valid),
        .wr_idx   (wr_idx),
        .wr_asid  (rf_asid),
        .wr_vpn   (rf_vpn),
        .wr_pfn   (rf_pfn),
        .wr_perm  (wr_perm),
        .hit_vec  (hit_vec),
        .dup_vec  (dup_vec),
        .hit_pfn  (hit_pfn),
        .hit_perm (hit_perm)
    );

    iotlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .lines   (lines_eff),
        .advance (advance),
        .slot    (slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_pend_q <= 1'b0;
            hit_q       <= 1'b0;
            miss_q      <= 1'b0;
            pfn_q       <= '0;
            perm_q      <= '0;
        end else begin
            miss_pend_q <= (accept && !any_hit) || (miss_pend_q && !rf_valid);
            hit_q       <= accept && any_hit;
            miss_q      <= accept && !any_hit;
            pfn_q       <= (accept && any_hit) ? hit_pfn : '0;
            perm_q      <= (accept && any_hit) ? hit_perm : '0;
        end
    end

    assign lk_hit  = hit_q;
    assign lk_miss = miss_q;
    assign lk_pfn  = pfn_q;
    assign lk_rd   = perm_q.rd;
    assign lk_wr   = perm_q.wr;
    assign lk_ns   = perm_q.ns;

endmodule

// File: rtl/iotlb_checker.sv
module iotlb_checker #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_ready,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               hum,
    input logic               wr_en,
    input logic               dup_any,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [CNT_W-1:0]   lines_eff,
    input logic [ENTRIES-1:0] dup_vec
);

    assert_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));

    assert_resp_R1: assert property (@(posedge clk) disable iff (rst)
        (lk_hit || lk_miss) |-> $past(lk_valid && lk_ready));

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!lk_hit && !lk_miss));

    assert_unique_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dup_vec));

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dup_any) |-> (CNT_W'(wr_idx) < lines_eff));

    assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (lk_miss && !hum) |-> !lk_ready);

endmodule

bind iotlb_top iotlb_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .hum       (hum_q),
    .wr_en     (rf_valid),
    .dup_any   (dup_any),
    .wr_idx    (wr_idx),
    .lines_eff (lines_eff),
    .dup_vec   (dup_vec)
);

// File: tb/iotlb_top_test.sv
module iotlb_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 16;
    localparam int PFN_W      = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_hum = 0;
    logic [5:0] cfg_lines = 0;
    logic fl_we = 0;
    logic [31:0] fl_cmd = 0;
    logic lk_valid = 0;
    logic [6:0] lk_asid = 0;
    logic [19:0] lk_vpn = 0;
    logic lk_ready, lk_hit, lk_miss, lk_rd, lk_wr, lk_ns;
    logic [PFN_W-1:0] lk_pfn;
    logic rf_valid = 0, rf_rd = 0, rf_wr = 0, rf_ns = 0;
    logic [6:0] rf_asid = 0;
    logic [19:0] rf_vpn = 0;
    logic [PFN_W-1:0] rf_pfn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iotlb_top #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_hit_under_miss(cfg_hum), .cfg_active_lines(cfg_lines),
        .fl_we(fl_we), .fl_cmd(fl_cmd),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
        .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_ns(lk_ns),
        .rf_valid(rf_valid), .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn),
        .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_ns(rf_ns)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R12";
    bit done = 0;

    // reference model
    bit              m_v [ENTRIES];
    bit [6:0]        m_a [ENTRIES];
    bit [19:0]       m_p [ENTRIES];
    bit [PFN_W-1:0]  m_f [ENTRIES];
    bit [2:0]        m_m [ENTRIES];
    int              m_ptr;
    bit              m_hum, m_pend, m_flp;
    int              m_lines;
    bit [31:0]       m_flc;
    bit              e_hit, e_miss;
    bit [PFN_W-1:0]  e_pfn;
    bit [2:0]        e_perm;

    function automatic bit sel_by_cmd(bit [31:0] c, bit [6:0] a, bit [19:0] p);
        bit asid_ok = !c[31] || (a == c[30:24]);
        case (c[1:0])
            2'd0: return asid_ok;
            2'd2: return asid_ok && (p[19:10] == c[19:10]);
            2'd3: return asid_ok && (p[19:2] == c[19:2]);
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < ENTRIES; k++) m_v[k] = 0;
        m_ptr = 0; m_hum = 1; m_pend = 0; m_flp = 0; m_lines = 0;
        e_hit = 0; e_miss = 0; e_pfn = 0; e_perm = 0;
    endtask

    task automatic model_edge();
        int L = (m_lines == 0 || m_lines > ENTRIES) ? ENTRIES : m_lines;
        bit acc = lk_valid && (m_hum || !m_pend);
        bit killed [ENTRIES];
        bit found = 0;
        int di = -1;
        bit [PFN_W-1:0] fp = 0;
        bit [2:0] fm = 0;
        for (int k = 0; k < ENTRIES; k++) begin
            killed[k] = m_flp && m_v[k] && sel_by_cmd(m_flc, m_a[k], m_p[k]);
            if (m_v[k] && !killed[k] && m_a[k] == lk_asid && m_p[k] == lk_vpn) begin
                found = 1; fp = m_f[k]; fm = m_m[k];
            end
            if (m_v[k] && m_a[k] == rf_asid && m_p[k] == rf_vpn) di = k;
        end
        e_hit  = acc && found;
        e_miss = acc && !found;
        e_pfn  = e_hit ? fp : '0;
        e_perm = e_hit ? fm : '0;
        for (int k = 0; k < ENTRIES; k++) if (killed[k]) m_v[k] = 0;
        if (rf_valid) begin
            int idx;
            int cur = (m_ptr >= L) ? 0 : m_ptr;
            idx = (di >= 0) ? di : cur;
            m_v[idx] = 1; m_a[idx] = rf_asid; m_p[idx] = rf_vpn;
            m_f[idx] = rf_pfn; m_m[idx] = {rf_rd, rf_wr, rf_ns};
            if (di < 0) m_ptr = (cur + 1 >= L) ? 0 : cur + 1;
        end
        m_pend = (acc && !found) || (m_pend && !rf_valid);
        m_flp = fl_we;
        m_flc = fl_cmd;
        if (cfg_we) begin m_hum = cfg_hum; m_lines = cfg_lines; end
    endtask

    task automatic check_vec(string req, logic [PFN_W+5:0] act, logic [PFN_W+5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {ready,hit,miss,pfn,perm} actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_vec(cur_req, {lk_ready, lk_hit, lk_miss, lk_pfn, lk_rd, lk_wr, lk_ns},
                  {m_hum || !m_pend, e_hit, e_miss, e_pfn, e_perm});
        cfg_we = 0; fl_we = 0; lk_valid = 0; rf_valid = 0;
    endtask

    task automatic lookup(bit [6:0] a, bit [19:0] p);
        lk_valid = 1; lk_asid = a; lk_vpn = p; cycle();
    endtask

    task automatic refill(bit [6:0] a, bit [19:0] p, bit [PFN_W-1:0] f, bit [2:0] m);
        rf_valid = 1; rf_asid = a; rf_vpn = p; rf_pfn = f; {rf_rd, rf_wr, rf_ns} = m; cycle();
    endtask

    task automatic flush(bit [31:0] c);
        fl_we = 1; fl_cmd = c; cycle(); cycle();
    endtask

    task automatic config_set(bit h, bit [5:0] l);
        cfg_we = 1; cfg_hum = h; cfg_lines = l; cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R12: reset state
        check_bit("R12", "lk_hit", lk_hit, 0);
        check_bit("R12", "lk_miss", lk_miss, 0);
        check_bit("R12", "lk_ready", lk_ready, 1);
        lookup(7'd1, 20'h12345);
        check_bit("R12", "miss after reset", lk_miss, 1);

        // R2 / R1
        cur_req = "R2";
        refill(7'd1, 20'h12345, 20'hABCDE, 3'b101);
        lookup(7'd1, 20'h12345);
        check_bit("R2", "hit next cycle", lk_hit, 1);
        cur_req = "R1";
        check_bit("R1", "pfn", lk_pfn == 20'hABCDE, 1);
        check_bit("R1", "perm rd/ns", {lk_rd, lk_wr, lk_ns} == 3'b101, 1);
        lookup(7'd2, 20'h12345);
        check_bit("R1", "other asid misses", lk_miss, 1);

        // R3: overwrite in place
        cur_req = "R3";
        refill(7'd1, 20'h12345, 20'h11111, 3'b110);
        lookup(7'd1, 20'h12345);
        check_bit("R3", "new pfn", lk_pfn == 20'h11111, 1);

        // R9: reserved mode
        cur_req = "R9";
        flush(32'h0000_0001);
        lookup(7'd1, 20'h12345);
        check_bit("R9", "survives mode 1", lk_hit, 1);

        // R7: section
        cur_req = "R7";
        refill(7'd1, 20'h12346, 20'h00002, 3'b111);
        refill(7'd1, 20'h12745, 20'h00003, 3'b111);
        flush(32'h8100_0000 | (32'h12345 & 32'hFFC00) | 32'h2);
        lookup(7'd1, 20'h12345);
        check_bit("R7", "same section gone", lk_miss, 1);
        lookup(7'd1, 20'h12346);
        check_bit("R7", "same section gone 2", lk_miss, 1);
        lookup(7'd1, 20'h12745);
        check_bit("R7", "next section kept", lk_hit, 1);

        // R8: group
        cur_req = "R8";
        refill(7'd3, 20'h00010, 20'h00010, 3'b100);
        refill(7'd3, 20'h00013, 20'h00013, 3'b100);
        refill(7'd3, 20'h00014, 20'h00014, 3'b100);
        flush(32'h8300_0000 | 32'h00010 | 32'h3);
        lookup(7'd3, 20'h00013);
        check_bit("R8", "group member gone", lk_miss, 1);
        lookup(7'd3, 20'h00014);
        check_bit("R8", "next group kept", lk_hit, 1);

        // R6: asid qualification
        cur_req = "R6";
        refill(7'd4, 20'h50000, 20'h00044, 3'b010);
        refill(7'd5, 20'h50000, 20'h00055, 3'b010);
        flush(32'h8400_0000);
        lookup(7'd4, 20'h50000);
        check_bit("R6", "selected asid gone", lk_miss, 1);
        lookup(7'd5, 20'h50000);
        check_bit("R6", "other asid kept", lk_hit, 1);

        // R10: flush timing
        cur_req = "R10";
        refill(7'd6, 20'h60000, 20'h00066, 3'b001);
        fl_we = 1; fl_cmd = 32'h8600_0000;
        lookup(7'd6, 20'h60000);
        check_bit("R10", "write cycle sees old", lk_hit, 1);
        lookup(7'd6, 20'h60000);
        check_bit("R10", "pending flush masks", lk_miss, 1);
        lookup(7'd6, 20'h60000);
        check_bit("R10", "applied", lk_miss, 1);

        // R13: flush and refill on one edge
        cur_req = "R13";
        fl_we = 1; fl_cmd = 32'h0;
        cycle();
        refill(7'd7, 20'h70000, 20'h00077, 3'b011);
        lookup(7'd7, 20'h70000);
        check_bit("R13", "refill survives", lk_hit, 1);

        // R5: global flush
        cur_req = "R5";
        flush(32'h0);
        lookup(7'd7, 20'h70000);
        check_bit("R5", "all gone", lk_miss, 1);
        lookup(7'd5, 20'h50000);
        check_bit("R5", "all gone 2", lk_miss, 1);

        // R4: active-line window
        cur_req = "R4";
        config_set(1'b1, 6'd2);
        refill(7'd8, 20'h00001, 20'h00081, 3'b100);
        refill(7'd8, 20'h00002, 20'h00082, 3'b100);
        refill(7'd8, 20'h00003, 20'h00083, 3'b100);
        lookup(7'd8, 20'h00001);
        check_bit("R4", "oldest evicted", lk_miss, 1);
        lookup(7'd8, 20'h00002);
        check_bit("R4", "second kept", lk_hit, 1);
        lookup(7'd8, 20'h00003);
        check_bit("R4", "third kept", lk_hit, 1);
        config_set(1'b1, 6'd0);

        // R11: hit-under-miss off
        cur_req = "R11";
        config_set(1'b0, 6'd0);
        lookup(7'd9, 20'h00009);
        check_bit("R11", "ready drops", lk_ready, 0);
        lookup(7'd8, 20'h00002);
        check_bit("R11", "blocked no hit", lk_hit, 0);
        check_bit("R11", "blocked no miss", lk_miss, 0);
        refill(7'd9, 20'h00009, 20'h00099, 3'b111);
        check_bit("R11", "ready back", lk_ready, 1);
        config_set(1'b1, 6'd0);
        lookup(7'd10, 20'h0000A);
        check_bit("R11", "hum keeps ready", lk_ready, 1);

        // random mix
        cur_req = "R1";
        for (int n = 0; n < 4000; n++) begin
            bit [19:0] pool [6] = '{20'h00000, 20'h00001, 20'h00004, 20'h00400, 20'h00401, 20'hFFFFF};
            lk_valid = ($urandom % 10) < 6;
            lk_asid  = 7'($urandom % 3);
            lk_vpn   = pool[$urandom % 6];
            rf_valid = ($urandom % 4) == 0;
            rf_asid  = 7'($urandom % 3);
            rf_vpn   = pool[$urandom % 6];
            rf_pfn   = PFN_W'($urandom);
            {rf_rd, rf_wr, rf_ns} = 3'($urandom);
            fl_we    = ($urandom % 25) == 0;
            fl_cmd   = {1'($urandom), 7'($urandom % 3), 4'h0, pool[$urandom % 6]};
            fl_cmd[1:0] = 2'($urandom);
            cfg_we   = ($urandom % 150) == 0;
            cfg_hum  = 1'($urandom);
            cfg_lines = 6'($urandom % 20);
            cycle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule